// File: doc/BRIEF.md
# Chip access window decoder

This block sits behind one serial slave and decodes that slave's 2 MiB address window. Requests come in on a valid/ready channel, one at a time. Each accepted request falls into one of four regions. The first region is a small read-only configuration table that the block answers itself. The second is the slave control register region, and the third is the local-bus region. Both of these are handed on through a one-hot select strobe and an offset that is relative to the start of the region. The fourth region is the unclaimed space between them, which reads as zero and drops writes.

The configuration table starts with a fixed chip identifier. Three engine description words follow it. Each description word has a "another entry follows" flag in bit 31, a slot count of one in bits 23:16, a version field, a type code in bits 7:4 and a 4-bit check code in bits 3:0. A write of the break value 0xC0DE0000 to either of the first two table words stores nothing. Instead it issues a one-clock cold-reset pulse to the local bus.

Responses leave on a second valid/ready channel. The block holds at most one response. While a response waits because `rsp_ready` is low, `req_ready` stays low, so back-pressure passes straight through to the requester. A response, once offered, does not change until it is taken. Data words are 32-bit values with bit 31 most significant. In byte order on a serial link, bits 31:24 go first.

Top module: `cam_window_dec`

## Requirements
- R1: Window decode on the byte offset `req_addr`. Offsets 0x000–0x3FF are the config table. Offsets 0x800–0xBFF are the slave region, and offsets 0xC00–0x1FFFFF are the local-bus region. Offsets 0x400–0x7FF are unclaimed: reads return zero, writes are dropped, and no select is raised.
- R2: A 4-byte read of config offset 0x000 returns 0xC0022D15.
- R3: A 4-byte read of config offset 0x004 returns 0x8001102C, offset 0x008 returns 0x8001503A, and offset 0x00C returns 0x80011067. Each of these words is built from the next flag (bit 31), a slot count of 0x01 (bits 23:16), the version, the type code shifted left by 4, and the check code.
- R4: A config read at any offset from 0x010 to 0x3FF returns zero.
- R5: A 4-byte write of 0xC0DE0000 to config offset 0x000 or 0x004 raises `lbus_cold_rst` high for exactly the one clock cycle that follows the acceptance edge.
- R6: A config write of any other value, or to any other config offset, produces no pulse and leaves every table word unchanged.
- R7: `req_size` gives the byte count (1, 2 or 4). In the config region, a size other than 4 completes with `rsp_err` = 1 and `rsp_rdata` = 0, and it has no side effect. Other regions accept any size and never flag an error.
- R8: The response appears on the cycle after acceptance. For slave and local-bus reads, `rsp_rdata` is the value of `slv_rdata` or `lbus_rdata` during the acceptance cycle. Write responses carry zero data.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, and `rsp_valid`, `rsp_rdata` and `rsp_err` hold their values.
- R10: After reset, `rsp_valid` = 0, `lbus_cold_rst` = 0 and `req_ready` = 1.
- R11: `slv_sel` and `lbus_sel` are high only during an acceptance cycle, and never both at once. Alongside them, `dn_offset` is the address minus the region base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 21 | Byte offset inside the slave window |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_size | input | 3 | Access size in bytes |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Illegal access size in config region |
| slv_sel | output | 1 | Strobe: request accepted for slave region |
| lbus_sel | output | 1 | Strobe: request accepted for local-bus region |
| dn_offset | output | 21 | Offset relative to the selected region base |
| dn_write | output | 1 | Write flag passed to the region |
| dn_wdata | output | 32 | Write data passed to the region |
| dn_size | output | 3 | Access size passed to the region |
| slv_rdata | input | 32 | Read data from the slave region, same cycle as `slv_sel` |
| lbus_rdata | input | 32 | Read data from the local bus, same cycle as `lbus_sel` |
| lbus_cold_rst | output | 1 | One-cycle cold-reset pulse to the local bus |

## Verification
The bound checker watches the handshake rules on every cycle. It confirms that back-pressure freezes the pending response and blocks new requests, and that every accepted request leads to a response. It also confirms that the two select strobes are exclusive, rise only on acceptance and fall in the right address range, that an error response carries no data, and that every cold-reset pulse comes from an accepted 4-byte break write to one of the two low words. The directed scenarios have to show the rest. That covers the table contents, the zero reads in unclaimed and empty table space, the relative offsets, the pass-through of downstream read data, and the cases where nothing happens: break writes to the wrong word, near-miss values, and short accesses that must not pulse or change the table.

// File: rtl/cam_win_pkg.sv
package cam_win_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    RGN_CFG  = 2'd0,
    RGN_SLV  = 2'd1,
    RGN_LBUS = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  // Fixed table contents
  localparam logic [WORD_W-1:0] CHIP_IDENT  = 32'hC002_2D15;
  localparam logic [WORD_W-1:0] BREAK_WORD  = 32'hC0DE_0000;
  localparam int unsigned       TBL_WORDS   = 4;  // identifier + three engines
  localparam int unsigned       BRK_WORDS   = 2;  // words that accept the break value
  localparam int unsigned       FULL_BYTES  = 4;

  // Engine type codes
  localparam logic [3:0] ENG_PEEK    = 4'h2;
  localparam logic [3:0] ENG_LINK    = 4'h3;
  localparam logic [3:0] ENG_SCRATCH = 4'h6;

  function automatic logic [WORD_W-1:0] engine_word(
      input logic        more,
      input logic [15:0] version,
      input logic [3:0]  kind,
      input logic [3:0]  check);
    logic [WORD_W-1:0] w;
    w = '0;
    w[31]    = more;
    w[23:16] = 8'h01;
    w        = w | {16'h0, version};
    w[7:4]   = w[7:4] | kind;
    w[3:0]   = w[3:0] | check;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] table_word(input int unsigned idx);
    case (idx)
      0:       return CHIP_IDENT;
      1:       return engine_word(1'b1, 16'h1000, ENG_PEEK,    4'hC);
      2:       return engine_word(1'b1, 16'h5000, ENG_LINK,    4'hA);
      3:       return engine_word(1'b1, 16'h1000, ENG_SCRATCH, 4'h7);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/cam_region_decode.sv
module cam_region_decode
  import cam_win_pkg::*;
#(
  parameter int unsigned ADDR_W    = 21,
  parameter int unsigned CFG_SPAN  = 'h400,
  parameter int unsigned SLV_BASE  = 'h800,
  parameter int unsigned SLV_SPAN  = 'h400,
  parameter int unsigned LBUS_BASE = 'hC00
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [ADDR_W-1:0] offset
);

  localparam logic [ADDR_W-1:0] CFG_END  = ADDR_W'(CFG_SPAN);
  localparam logic [ADDR_W-1:0] SLV_LO   = ADDR_W'(SLV_BASE);
  localparam logic [ADDR_W-1:0] SLV_END  = ADDR_W'(SLV_BASE + SLV_SPAN);
  localparam logic [ADDR_W-1:0] LBUS_LO  = ADDR_W'(LBUS_BASE);

  always_comb begin
    region = RGN_NONE;
    offset = '0;
    if (addr < CFG_END) begin
      region = RGN_CFG;
      offset = addr;
    end else if (addr >= SLV_LO && addr < SLV_END) begin
      region = RGN_SLV;
      offset = addr - SLV_LO;
    end else if (addr >= LBUS_LO) begin
      region = RGN_LBUS;
      offset = addr - LBUS_LO;
    end
  end

endmodule

// File: rtl/cam_cfg_table.sv
module cam_cfg_table
  import cam_win_pkg::*;
#(
  parameter int unsigned IDX_W = 19
) (
  input  logic [IDX_W-1:0]  word_idx,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              size_ok,
  output logic [WORD_W-1:0] rdata,
  output logic              brk_hit
);

  localparam int unsigned SEL_W = $clog2(TBL_WORDS);

  logic [WORD_W-1:0] entry [TBL_WORDS];

  for (genvar g = 0; g < TBL_WORDS; g++) begin : g_entry
    assign entry[g] = table_word(g);
  end

  logic in_table;
  logic in_brk;

  assign in_table = (word_idx < IDX_W'(TBL_WORDS));
  assign in_brk   = (word_idx < IDX_W'(BRK_WORDS));

  always_comb begin
    rdata = '0;
    if (in_table) rdata = entry[word_idx[SEL_W-1:0]];
  end

  assign brk_hit = wr && size_ok && in_brk && (wdata == BREAK_WORD);

endmodule

// File: rtl/cam_rsp_stage.sv
module cam_rsp_stage
  import cam_win_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              ld_err,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              can_take
);

  assign can_take = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= ld_data;
      rsp_err   <= ld_err;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/cam_window_dec.sv
module cam_window_dec
  import cam_win_pkg::*;
#(
  parameter int unsigned ADDR_W    = 21,
  parameter int unsigned SIZE_W    = 3,
  parameter int unsigned CFG_SPAN  = 'h400,
  parameter int unsigned SLV_BASE  = 'h800,
  parameter int unsigned SLV_SPAN  = 'h400,
  parameter int unsigned LBUS_BASE = 'hC00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  input  logic [SIZE_W-1:0] req_size,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              slv_sel,
  output logic              lbus_sel,
  output logic [ADDR_W-1:0] dn_offset,
  output logic              dn_write,
  output logic [31:0]       dn_wdata,
  output logic [SIZE_W-1:0] dn_size,
  input  logic [31:0]       slv_rdata,
  input  logic [31:0]       lbus_rdata,
  output logic              lbus_cold_rst
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  region_e           region;
  logic [ADDR_W-1:0] offset;
  logic              accept;
  logic              size_ok;
  logic [31:0]       cfg_rdata;
  logic              brk_hit;
  logic [31:0]       rd_mux;
  logic              err_now;
  logic              cold_q;

  cam_region_decode #(
    .ADDR_W   (ADDR_W),
    .CFG_SPAN (CFG_SPAN),
    .SLV_BASE (SLV_BASE),
    .SLV_SPAN (SLV_SPAN),
    .LBUS_BASE(LBUS_BASE)
  ) u_decode (
    .addr  (req_addr),
    .region(region),
    .offset(offset)
  );

  assign size_ok = (req_size == SIZE_W'(FULL_BYTES));

  cam_cfg_table #(
    .IDX_W(IDX_W)
  ) u_table (
    .word_idx(offset[ADDR_W-1:2]),
    .wr      (req_write),
    .wdata   (req_wdata),
    .size_ok (size_ok),
    .rdata   (cfg_rdata),
    .brk_hit (brk_hit)
  );

  assign accept  = req_valid && req_ready;
  assign err_now = (region == RGN_CFG) && !size_ok;

  always_comb begin
    rd_mux = '0;
    if (!req_write) begin
      case (region)
        RGN_CFG:  rd_mux = size_ok ? cfg_rdata : '0;
        RGN_SLV:  rd_mux = slv_rdata;
        RGN_LBUS: rd_mux = lbus_rdata;
        default:  rd_mux = '0;
      endcase
    end
  end

  cam_rsp_stage u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .ld_data  (rd_mux),
    .ld_err   (err_now),
    .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .rsp_err  (rsp_err),
    .can_take (req_ready)
  );

  assign slv_sel   = accept && (region == RGN_SLV);
  assign lbus_sel  = accept && (region == RGN_LBUS);
  assign dn_offset = offset;
  assign dn_write  = req_write;
  assign dn_wdata  = req_wdata;
  assign dn_size   = req_size;

  always_ff @(posedge clk) begin
    if (!rst_n) cold_q <= 1'b0;
    else        cold_q <= accept && (region == RGN_CFG) && brk_hit;
  end

  assign lbus_cold_rst = cold_q;

endmodule

// File: rtl/cam_window_dec_chk.sv
module cam_window_dec_chk #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned SIZE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic [31:0]       req_wdata,
  input logic [SIZE_W-1:0] req_size,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic              slv_sel,
  input logic              lbus_sel,
  input logic              lbus_cold_rst
);

  // R11
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({slv_sel, lbus_sel}));

  // R11
  sel_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_sel || lbus_sel) |-> (req_valid && req_ready));

  // R1
  slv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slv_sel |-> (req_addr >= ADDR_W'('h800) && req_addr < ADDR_W'('hC00)));

  // R1
  lbus_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lbus_sel |-> (req_addr >= ADDR_W'('hC00)));

  // R9
  hold_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R9
  rsp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  // R8
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R7
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 32'h0));

  // R5
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lbus_cold_rst |-> $past(req_valid && req_ready && req_write &&
                            req_size == SIZE_W'(4) && req_wdata == 32'hC0DE_0000 &&
                            req_addr[ADDR_W-1:3] == '0));

endmodule

bind cam_window_dec cam_window_dec_chk #(
  .ADDR_W(ADDR_W),
  .SIZE_W(SIZE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_addr     (req_addr),
  .req_write    (req_write),
  .req_wdata    (req_wdata),
  .req_size     (req_size),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_rdata    (rsp_rdata),
  .rsp_err      (rsp_err),
  .slv_sel      (slv_sel),
  .lbus_sel     (lbus_sel),
  .lbus_cold_rst(lbus_cold_rst)
);

// File: tb/cam_window_dec_test.sv
module cam_window_dec_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [20:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [2:0]  req_size = 3'd4;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        slv_sel;
  logic        lbus_sel;
  logic [20:0] dn_offset;
  logic        dn_write;
  logic [31:0] dn_wdata;
  logic [2:0]  dn_size;
  logic [31:0] slv_rdata = 32'h5A5A_0001;
  logic [31:0] lbus_rdata = 32'h1BB5_0002;
  logic        lbus_cold_rst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cam_window_dec uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .slv_sel(slv_sel), .lbus_sel(lbus_sel),
    .dn_offset(dn_offset), .dn_write(dn_write), .dn_wdata(dn_wdata),
    .dn_size(dn_size), .slv_rdata(slv_rdata), .lbus_rdata(lbus_rdata),
    .lbus_cold_rst(lbus_cold_rst)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One transfer; samples strobes in the accept cycle, response the cycle after,
  // and the reset pulse one further cycle later.
  task automatic xfer(input logic [20:0] a, input logic w, input logic [31:0] d,
                      input logic [2:0] sz,
                      output logic [31:0] rd, output logic er,
                      output logic sl, output logic lb, output logic [20:0] off,
                      output logic pulse, output logic pulse_after);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d; req_size = sz;
    #1;
    sl = slv_sel; lb = lbus_sel; off = dn_offset;
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; er = rsp_err; pulse = lbus_cold_rst;
    check("R8 rsp_valid after accept", {31'b0, rsp_valid}, 32'd1);
    @(negedge clk);
    pulse_after = lbus_cold_rst;
  endtask

  task automatic t_reset;
    check("R10 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R10 req_ready", {31'b0, req_ready}, 32'd1);
    check("R10 lbus_cold_rst", {31'b0, lbus_cold_rst}, 32'd0);
  endtask

  task automatic t_table;
    logic [31:0] rd; logic er, sl, lb, p, pa; logic [20:0] off;
    xfer(21'h000, 1'b0, 0, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R2 chip id", rd, 32'hC002_2D15);
    check("R2 no err", {31'b0, er}, 32'd0);
    xfer(21'h004, 1'b0, 0, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R3 peek entry", rd, 32'h8001_102C);
    xfer(21'h008, 1'b0, 0, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R3 link entry", rd, 32'h8001_503A);
    xfer(21'h00C, 1'b0, 0, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R3 scratch entry", rd, 32'h8001_1067);
    xfer(21'h010, 1'b0, 0, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R4 offset 0x010", rd, 32'h0);
    xfer(21'h3FC, 1'b0, 0, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R4 offset 0x3FC", rd, 32'h0);
    check("R11 no sel in cfg", {30'b0, sl, lb}, 32'd0);
  endtask

  task automatic t_regions;
    logic [31:0] rd; logic er, sl, lb, p, pa; logic [20:0] off;
    xfer(21'h800, 1'b0, 0, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R11 slv sel", {30'b0, sl, lb}, 32'd2);
    check("R11 slv offset", {11'b0, off}, 32'h0);
    check("R8 slv data", rd, 32'h5A5A_0001);
    xfer(21'h9F4, 1'b0, 0, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R11 slv offset 0x1F4", {11'b0, off}, 32'h1F4);
    xfer(21'hC00, 1'b0, 0, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R11 lbus sel", {30'b0, sl, lb}, 32'd1);
    check("R8 lbus data", rd, 32'h1BB5_0002);
    xfer(21'h1FFFFC, 1'b0, 0, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R1 lbus top offset", {11'b0, off}, 32'h1FF3FC);
    xfer(21'h400, 1'b0, 0, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R1 unclaimed read zero", rd, 32'h0);
    check("R1 unclaimed no sel", {30'b0, sl, lb}, 32'd0);
    xfer(21'h7FC, 1'b1, 32'hC0DE_0000, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R1 unclaimed write no sel", {30'b0, sl, lb}, 32'd0);
    check("R1 unclaimed write no pulse", {31'b0, p}, 32'd0);
    xfer(21'h808, 1'b1, 32'h1234_5678, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R8 write rsp zero", rd, 32'h0);
  endtask

  task automatic t_break;
    logic [31:0] rd; logic er, sl, lb, p, pa; logic [20:0] off;
    xfer(21'h000, 1'b1, 32'hC0DE_0000, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R5 pulse word 0", {31'b0, p}, 32'd1);
    check("R5 pulse ends word 0", {31'b0, pa}, 32'd0);
    xfer(21'h004, 1'b1, 32'hC0DE_0000, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R5 pulse word 1", {31'b0, p}, 32'd1);
    check("R5 pulse ends word 1", {31'b0, pa}, 32'd0);
    xfer(21'h000, 1'b0, 0, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R5 id kept after break", rd, 32'hC002_2D15);
  endtask

  task automatic t_ignore;
    logic [31:0] rd; logic er, sl, lb, p, pa; logic [20:0] off;
    xfer(21'h008, 1'b1, 32'hC0DE_0000, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R6 break at word 2 no pulse", {31'b0, p}, 32'd0);
    xfer(21'h000, 1'b1, 32'hC0DE_0001, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R6 near value no pulse", {31'b0, p}, 32'd0);
    xfer(21'h004, 1'b1, 32'hFFFF_FFFF, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R6 other value no pulse", {31'b0, p}, 32'd0);
    xfer(21'h004, 1'b0, 0, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R6 peek entry unchanged", rd, 32'h8001_102C);
    xfer(21'h008, 1'b0, 0, 3'd4, rd, er, sl, lb, off, p, pa);
    check("R6 link entry unchanged", rd, 32'h8001_503A);
  endtask

  task automatic t_size;
    logic [31:0] rd; logic er, sl, lb, p, pa; logic [20:0] off;
    xfer(21'h000, 1'b0, 0, 3'd2, rd, er, sl, lb, off, p, pa);
    check("R7 short read err", {31'b0, er}, 32'd1);
    check("R7 short read data zero", rd, 32'h0);
    xfer(21'h000, 1'b1, 32'hC0DE_0000, 3'd1, rd, er, sl, lb, off, p, pa);
    check("R7 short break err", {31'b0, er}, 32'd1);
    check("R7 short break no pulse", {31'b0, p}, 32'd0);
    xfer(21'h800, 1'b0, 0, 3'd2, rd, er, sl, lb, off, p, pa);
    check("R7 slv short no err", {31'b0, er}, 32'd0);
    check("R7 slv short data", rd, 32'h5A5A_0001);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 21'h000; req_write = 1'b0; req_size = 3'd4;
    @(negedge clk);
    req_addr = 21'h004;
    check("R9 pending valid", {31'b0, rsp_valid}, 32'd1);
    check("R9 req blocked", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    check("R9 data held", rsp_rdata, 32'hC002_2D15);
    check("R9 still blocked", {31'b0, req_ready}, 32'd0);
    rsp_ready = 1'b1;
    #1;
    check("R9 ready on release", {31'b0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 next response", rsp_rdata, 32'h8001_102C);
    @(negedge clk);
    check("R9 drained", {31'b0, rsp_valid}, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_table();
    t_regions();
    t_break();
    t_ignore();
    t_size();
    t_backpressure();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule